// File: doc/BRIEF.md
# DMA Channel Transfer Sequencer

One channel of a high-speed DMA engine. Software programs a small register set through a word-indexed write/read port: a control word, a source address, a destination address, a transfer count and an enable bit. A trigger pulse on an enabled channel marks a transfer as pending. The sequencer then drives a simple request/grant bus. Each unit of data is one bus phase in single-address operation, or two phases (a read, then a write) in dual-address operation. After each unit the sequencer steps the addresses and counts down.

The count register is read in one of two ways, set by the transfer mode. In single and successive mode it is one 24-bit unit count. In block mode it holds an 8-bit block length and a 16-bit block count. Addresses can stay fixed, count down, count up, or count up and return to their programmed start value at every block boundary. When the count is used up the channel pulses `done_o` and disables itself.

Top module: `dma_chan_seq`

## Requirements
- R1: Word index 0 is the control word, with xfer mode [1:0], source address control [3:2], destination address control [5:4], dual-address select [6] and direction [7]. Index 1 is the source address (28 bits). Index 2 is the destination address (28 bits). Index 3 is the count (24 bits). Index 4 bit 0 is enable. Index 5 bit 0 is the trigger flag. Unimplemented bits and indices 6 and 7 read as 0.
- R2: Address control 00 keeps the address fixed, 01 decrements by 1, 10 increments by 1 and reloads the start value at each block end, and 11 increments by 1 with no reload. The address wraps modulo 2^28, and readback returns the current address.
- R3: In mode 00 (single), each accepted trigger moves exactly one unit, and the 24-bit count drops by 1.
- R4: In mode 01 (successive), one accepted trigger moves units back to back until the count reaches 0.
- R5: In mode 10 (block), count bits [7:0] are the block length (0 means 256) and bits [23:8] are the block count. One trigger moves one block, the block count drops by 1 per block, and the length field is kept.
- R6: With dual select 1, a unit is a read phase at the source address (`req_we_o`=0) followed by a write phase at the destination address (`req_we_o`=1). With dual select 0, a unit is one phase at the source address with `req_we_o` equal to the direction bit, and the destination address does not step.
- R7: The last unit's grant is followed one cycle later by a single-cycle `done_o` pulse, and enable is cleared. An accepted trigger on a zero count (or zero block count in block mode) completes in the same way with no bus request.
- R8: Enable resets to 0. While it is 0, a trigger leaves the flag at 0 and starts nothing.
- R9: A trigger on an enabled channel with a valid mode sets the flag. Writing 1 to bit 0 of index 5 clears it, writing 0 leaves it unchanged, and starting a transfer consumes it.
- R10: With mode 11 a trigger sets no flag, raises no request and changes no register.
- R11: Once raised, `req_o`, `req_addr_o` and `req_we_o` hold steady until `gnt_i` is seen high.
- R12: While a transfer is in progress, writes to indices 0 to 4 are ignored. Only the trigger-flag clear takes effect.
- R13: After reset every register reads 0, and `req_o` and `done_o` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cfg_we_i | input | 1 | Register write strobe |
| cfg_addr_i | input | 3 | Register word index |
| cfg_wdata_i | input | DW | Register write data |
| cfg_rdata_o | output | DW | Register read data (combinational on index) |
| trig_i | input | 1 | Transfer trigger |
| req_o | output | 1 | Bus phase request |
| req_we_o | output | 1 | Phase is a write (1) or a read (0) |
| req_addr_o | output | AW | Phase address |
| gnt_i | input | 1 | Bus grant; a phase completes on a clock edge with `req_o` and `gnt_i` high |
| done_o | output | 1 | One-cycle completion pulse |

## Verification
The bench sweeps every valid mode against all sixteen pairs of source and destination address control, in both single and dual address operation. The start addresses sit at the wrap points, so a decrement or increment that fails to wrap modulo 2^28 shows up. Single mode with two triggers separates per-trigger stepping from a free run, successive mode checks that no gap opens between units, and two blocks of three units expose a missing reload or a lost block decrement. The directed cases target one mechanism each: a zero count, a block length of 0, a stalled grant (hold, flag clear semantics, write lock), a disabled channel and the invalid mode.

// File: rtl/dma_chan_pkg.sv
package dma_chan_pkg;
  typedef enum logic [1:0] {
    XM_SINGLE = 2'b00,
    XM_SUCC   = 2'b01,
    XM_BLOCK  = 2'b10,
    XM_BAD    = 2'b11
  } xmode_e;

  typedef enum logic [1:0] {
    AC_FIXED   = 2'b00,
    AC_DEC     = 2'b01,
    AC_INC_RLD = 2'b10,
    AC_INC     = 2'b11
  } actl_e;

  typedef enum logic [1:0] {
    ST_IDLE = 2'b00,
    ST_PH_A = 2'b01,
    ST_PH_B = 2'b10
  } seq_st_e;

  typedef struct packed {
    logic   dir;
    logic   dual;
    actl_e  dctl;
    actl_e  sctl;
    xmode_e mode;
  } ctrl_t;

  localparam int CTRL_W = 8;

  localparam logic [2:0] RA_CTRL = 3'd0;
  localparam logic [2:0] RA_SRC  = 3'd1;
  localparam logic [2:0] RA_DST  = 3'd2;
  localparam logic [2:0] RA_CNT  = 3'd3;
  localparam logic [2:0] RA_EN   = 3'd4;
  localparam logic [2:0] RA_TRIG = 3'd5;
endpackage

// File: rtl/dma_addr_unit.sv
module dma_addr_unit
  import dma_chan_pkg::*;
#(
  parameter int AW = 28
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          wr_i,
  input  logic [AW-1:0] wdata_i,
  input  logic          step_i,
  input  logic          blk_end_i,
  input  actl_e         ctl_i,
  output logic [AW-1:0] addr_o
);
  logic [AW-1:0] base_q, cur_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      base_q <= '0;
      cur_q  <= '0;
    end else if (wr_i) begin
      base_q <= wdata_i;
      cur_q  <= wdata_i;
    end else if (step_i) begin
      if (blk_end_i && ctl_i == AC_INC_RLD) begin
        cur_q <= base_q;
      end else begin
        case (ctl_i)
          AC_FIXED: cur_q <= cur_q;
          AC_DEC:   cur_q <= cur_q - AW'(1);
          default:  cur_q <= cur_q + AW'(1);
        endcase
      end
    end
  end

  assign addr_o = cur_q;

  assert_fixed_hold_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!wr_i && ctl_i == AC_FIXED) |=> $stable(cur_q));
endmodule

// File: rtl/dma_regs.sv
module dma_regs
  import dma_chan_pkg::*;
#(
  parameter int AW = 28,
  parameter int CW = 24,
  parameter int LW = 8,
  parameter int DW = 32
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          we_i,
  input  logic [2:0]    addr_i,
  input  logic [DW-1:0] wdata_i,
  output logic [DW-1:0] rdata_o,
  input  logic          busy_i,
  input  logic          trig_i,
  input  logic          accept_i,
  input  logic          cnt_dec_i,
  input  logic          blk_dec_i,
  input  logic          fin_i,
  input  logic [AW-1:0] src_addr_i,
  input  logic [AW-1:0] dst_addr_i,
  output ctrl_t         ctrl_o,
  output logic [CW-1:0] cnt_o,
  output logic          en_o,
  output logic          flag_o,
  output logic          src_wr_o,
  output logic          dst_wr_o
);
  localparam int BW = CW - LW;

  ctrl_t         ctrl_q;
  logic [CW-1:0] cnt_q;
  logic          en_q, flag_q;
  logic          wr_ok, trig_ok, sw_clr;
  logic          unused_wdata;

  assign unused_wdata = ^wdata_i[DW-1:AW];
  assign wr_ok    = we_i && !busy_i;
  assign src_wr_o = wr_ok && addr_i == RA_SRC;
  assign dst_wr_o = wr_ok && addr_i == RA_DST;
  assign trig_ok  = trig_i && en_q && ctrl_q.mode != XM_BAD;
  assign sw_clr   = we_i && addr_i == RA_TRIG && wdata_i[0];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) ctrl_q <= '0;
    else if (wr_ok && addr_i == RA_CTRL) ctrl_q <= ctrl_t'(wdata_i[CTRL_W-1:0]);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= '0;
    else if (wr_ok && addr_i == RA_CNT) cnt_q <= wdata_i[CW-1:0];
    else if (cnt_dec_i) cnt_q <= cnt_q - CW'(1);
    else if (blk_dec_i) cnt_q[CW-1:LW] <= cnt_q[CW-1:LW] - BW'(1);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) en_q <= 1'b0;
    else if (fin_i) en_q <= 1'b0;
    else if (wr_ok && addr_i == RA_EN) en_q <= wdata_i[0];
  end

  // a fresh trigger wins over a clear in the same cycle
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) flag_q <= 1'b0;
    else if (trig_ok) flag_q <= 1'b1;
    else if (accept_i || sw_clr) flag_q <= 1'b0;
  end

  always_comb begin
    rdata_o = '0;
    case (addr_i)
      RA_CTRL: rdata_o[CTRL_W-1:0] = ctrl_q;
      RA_SRC:  rdata_o[AW-1:0]     = src_addr_i;
      RA_DST:  rdata_o[AW-1:0]     = dst_addr_i;
      RA_CNT:  rdata_o[CW-1:0]     = cnt_q;
      RA_EN:   rdata_o[0]          = en_q;
      RA_TRIG: rdata_o[0]          = flag_q;
      default: rdata_o = '0;
    endcase
  end

  assign ctrl_o = ctrl_q;
  assign cnt_o  = cnt_q;
  assign en_o   = en_q;
  assign flag_o = flag_q;

  assert_fin_disables_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fin_i |=> !en_q);
  assert_no_flag_disabled_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!en_q && !flag_q) |=> !flag_q);
  assert_busy_lock_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_i |=> $stable(ctrl_q));
endmodule

// File: rtl/dma_seq.sv
module dma_seq
  import dma_chan_pkg::*;
#(
  parameter int CW = 24,
  parameter int LW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  xmode_e        mode_i,
  input  logic          dual_i,
  input  logic          dir_i,
  input  logic [CW-1:0] cnt_i,
  input  logic          en_i,
  input  logic          flag_i,
  input  logic          gnt_i,
  output logic          req_o,
  output logic          req_we_o,
  output logic          sel_dst_o,
  output logic          busy_o,
  output logic          accept_o,
  output logic          cnt_dec_o,
  output logic          blk_dec_o,
  output logic          src_step_o,
  output logic          dst_step_o,
  output logic          blk_end_o,
  output logic          fin_o,
  output logic          done_o
);
  localparam int BW  = CW - LW;
  localparam int ULW = LW + 1;

  seq_st_e        st_q, st_d, after_unit;
  logic [ULW-1:0] units_q;
  logic           done_q;
  logic           is_blk, start, unit_end, blk_last, cnt_zero, cnt_last, fin;
  logic [BW-1:0]  blocks;
  logic [LW-1:0]  blen;

  assign is_blk = mode_i == XM_BLOCK;
  assign blocks = cnt_i[CW-1:LW];
  assign blen   = cnt_i[LW-1:0];

  always_comb begin
    start    = st_q == ST_IDLE && en_i && flag_i && mode_i != XM_BAD;
    unit_end = gnt_i && ((st_q == ST_PH_A && !dual_i) || st_q == ST_PH_B);
    blk_last = units_q == ULW'(1);
    cnt_zero = is_blk ? (blocks == '0) : (cnt_i == '0);
    cnt_last = is_blk ? (blocks == BW'(1)) : (cnt_i == CW'(1));
    fin      = (start && cnt_zero) || (unit_end && cnt_last && (!is_blk || blk_last));

    if (fin || mode_i == XM_SINGLE || (is_blk && blk_last)) after_unit = ST_IDLE;
    else after_unit = ST_PH_A;

    st_d = st_q;
    case (st_q)
      ST_IDLE: if (start && !cnt_zero) st_d = ST_PH_A;
      ST_PH_A: if (gnt_i) st_d = dual_i ? ST_PH_B : after_unit;
      ST_PH_B: if (gnt_i) st_d = after_unit;
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q    <= ST_IDLE;
      units_q <= '0;
      done_q  <= 1'b0;
    end else begin
      st_q   <= st_d;
      done_q <= fin;
      if (start) units_q <= (blen == '0) ? {1'b1, {LW{1'b0}}} : {1'b0, blen};
      else if (unit_end && is_blk) units_q <= units_q - ULW'(1);
    end
  end

  assign req_o      = st_q != ST_IDLE;
  assign sel_dst_o  = st_q == ST_PH_B;
  assign req_we_o   = (st_q == ST_PH_B) ? 1'b1 : (dual_i ? 1'b0 : dir_i);
  assign busy_o     = st_q != ST_IDLE;
  assign accept_o   = start;
  assign cnt_dec_o  = unit_end && !is_blk;
  assign blk_end_o  = unit_end && is_blk && blk_last;
  assign blk_dec_o  = blk_end_o;
  assign src_step_o = unit_end;
  assign dst_step_o = unit_end && dual_i;
  assign fin_o      = fin;
  assign done_o     = done_q;

  assert_done_pulse_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
  assert_invalid_idle_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i == XM_BAD) |-> (st_q == ST_IDLE));
  assert_units_live_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q != ST_IDLE && is_blk) |-> (units_q != '0));
endmodule

// File: rtl/dma_chan_seq.sv
module dma_chan_seq
  import dma_chan_pkg::*;
#(
  parameter int AW = 28,
  parameter int CW = 24,
  parameter int LW = 8,
  parameter int DW = 32
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          cfg_we_i,
  input  logic [2:0]    cfg_addr_i,
  input  logic [DW-1:0] cfg_wdata_i,
  output logic [DW-1:0] cfg_rdata_o,
  input  logic          trig_i,
  output logic          req_o,
  output logic          req_we_o,
  output logic [AW-1:0] req_addr_o,
  input  logic          gnt_i,
  output logic          done_o
);
  ctrl_t         ctrl;
  logic [CW-1:0] cnt;
  logic          en, flag, busy, accept, cnt_dec, blk_dec, fin;
  logic          src_step, dst_step, blk_end, sel_dst, src_wr, dst_wr;
  logic [AW-1:0] src_addr, dst_addr;

  dma_regs #(.AW(AW), .CW(CW), .LW(LW), .DW(DW)) u_regs (
    .clk_i, .rst_ni,
    .we_i(cfg_we_i), .addr_i(cfg_addr_i), .wdata_i(cfg_wdata_i), .rdata_o(cfg_rdata_o),
    .busy_i(busy), .trig_i(trig_i), .accept_i(accept), .cnt_dec_i(cnt_dec),
    .blk_dec_i(blk_dec), .fin_i(fin), .src_addr_i(src_addr), .dst_addr_i(dst_addr),
    .ctrl_o(ctrl), .cnt_o(cnt), .en_o(en), .flag_o(flag),
    .src_wr_o(src_wr), .dst_wr_o(dst_wr)
  );

  dma_seq #(.CW(CW), .LW(LW)) u_seq (
    .clk_i, .rst_ni,
    .mode_i(ctrl.mode), .dual_i(ctrl.dual), .dir_i(ctrl.dir),
    .cnt_i(cnt), .en_i(en), .flag_i(flag), .gnt_i(gnt_i),
    .req_o(req_o), .req_we_o(req_we_o), .sel_dst_o(sel_dst), .busy_o(busy),
    .accept_o(accept), .cnt_dec_o(cnt_dec), .blk_dec_o(blk_dec),
    .src_step_o(src_step), .dst_step_o(dst_step), .blk_end_o(blk_end),
    .fin_o(fin), .done_o(done_o)
  );

  dma_addr_unit #(.AW(AW)) u_src (
    .clk_i, .rst_ni, .wr_i(src_wr), .wdata_i(cfg_wdata_i[AW-1:0]),
    .step_i(src_step), .blk_end_i(blk_end), .ctl_i(ctrl.sctl), .addr_o(src_addr)
  );

  dma_addr_unit #(.AW(AW)) u_dst (
    .clk_i, .rst_ni, .wr_i(dst_wr), .wdata_i(cfg_wdata_i[AW-1:0]),
    .step_i(dst_step), .blk_end_i(blk_end), .ctl_i(ctrl.dctl), .addr_o(dst_addr)
  );

  assign req_addr_o = sel_dst ? dst_addr : src_addr;

  assert_hold_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_o && !gnt_i) |=> (req_o && $stable(req_addr_o) && $stable(req_we_o)));
  assert_single_no_dst_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_o && !ctrl.dual) |=> $stable(dst_addr));
endmodule

// File: tb/sim_dma_chan_seq.sv
`timescale 1ns/1ps
module sim_dma_chan_seq;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        cfg_we = 1'b0;
  logic [2:0]  cfg_addr = '0;
  logic [31:0] cfg_wdata = '0;
  logic [31:0] cfg_rdata;
  logic        trig = 1'b0;
  logic        gnt = 1'b1;
  logic        req, req_we, done;
  logic [27:0] req_addr;
  int n_chk = 0, n_bad = 0, done_cnt = 0;

  always #2.5 clk = ~clk;

  dma_chan_seq u0 (
    .clk_i(clk), .rst_ni(rst_ni), .cfg_we_i(cfg_we), .cfg_addr_i(cfg_addr),
    .cfg_wdata_i(cfg_wdata), .cfg_rdata_o(cfg_rdata), .trig_i(trig),
    .req_o(req), .req_we_o(req_we), .req_addr_o(req_addr), .gnt_i(gnt), .done_o(done)
  );

  always @(negedge clk) if (done) done_cnt++;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk); cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
    @(negedge clk); cfg_we = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] d);
    @(negedge clk); cfg_addr = a; #1 d = cfg_rdata;
  endtask

  task automatic pulse_trig();
    @(negedge clk); trig = 1'b1;
    @(negedge clk); trig = 1'b0;
  endtask

  task automatic wait_req(input string tag);
    int t = 0;
    while (!req && t < 1000) begin @(negedge clk); t++; end
    if (!req) chk({tag, " request timeout"}, 32'd0, 32'd1);
  endtask

  task automatic no_req(input string tag, input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      chk({tag, " no request"}, {31'd0, req}, 32'd0);
    end
  endtask

  function automatic logic [27:0] stp(input logic [27:0] a, input int c);
    case (c)
      0: return a;
      1: return a - 28'd1;
      default: return a + 28'd1;
    endcase
  endfunction

  task automatic do_unit(input string rq, input int sc, input int dc, input int du,
                         input logic dirb, inout logic [27:0] es, inout logic [27:0] ed);
    wait_req(rq);
    chk({rq, " R6 phase-a addr"}, {4'd0, req_addr}, {4'd0, es});
    chk({rq, " R6 phase-a we"}, {31'd0, req_we}, {31'd0, (du != 0) ? 1'b0 : dirb});
    @(negedge clk);
    if (du != 0) begin
      chk({rq, " R6 phase-b addr"}, {4'd0, req_addr}, {4'd0, ed});
      chk({rq, " R6 phase-b we"}, {31'd0, req_we}, 32'd1);
      @(negedge clk);
    end
    es = stp(es, sc);
    if (du != 0) ed = stp(ed, dc);
  endtask

  task automatic run_case(input int m, input int sc, input int dc, input int du,
                          input logic [27:0] s0, input logic [27:0] d0, input logic [23:0] c0);
    logic [27:0] es, ed;
    logic [31:0] v;
    logic        dirb;
    int          base, nb, nl;
    string       rq;
    dirb = sc[0];
    rq = (m == 0) ? "R3" : (m == 1) ? "R4" : "R5";
    wr(3'd0, {24'd0, dirb, du[0], dc[1:0], sc[1:0], m[1:0]});
    wr(3'd1, {4'd0, s0});
    wr(3'd2, {4'd0, d0});
    wr(3'd3, {8'd0, c0});
    wr(3'd4, 32'd1);
    es = s0; ed = d0; base = done_cnt;
    if (m == 0) begin
      for (int i = 0; i < int'(c0); i++) begin
        pulse_trig();
        do_unit(rq, sc, dc, du, dirb, es, ed);
        chk("R3 idle after one unit", {31'd0, req}, 32'd0);
        rd(3'd3, v);
        chk("R3 count readback", v, c0 - 24'(i) - 24'd1);
      end
    end else if (m == 1) begin
      pulse_trig();
      for (int i = 0; i < int'(c0); i++) do_unit(rq, sc, dc, du, dirb, es, ed);
      chk("R4 idle at count zero", {31'd0, req}, 32'd0);
      rd(3'd3, v);
      chk("R4 count readback", v, 32'd0);
    end else begin
      nb = int'(c0[23:8]);
      nl = (c0[7:0] == 8'd0) ? 256 : int'(c0[7:0]);
      for (int b = 0; b < nb; b++) begin
        pulse_trig();
        for (int u = 0; u < nl; u++) do_unit(rq, sc, dc, du, dirb, es, ed);
        if (sc == 2) es = s0;
        if (du != 0 && dc == 2) ed = d0;
        chk("R5 idle after block", {31'd0, req}, 32'd0);
        rd(3'd3, v);
        chk("R5 count readback", v, {8'd0, 16'(nb - b - 1), c0[7:0]});
      end
    end
    repeat (2) @(negedge clk);
    chk("R7 one done pulse", 32'(done_cnt - base), 32'd1);
    rd(3'd4, v); chk("R7 enable cleared", v, 32'd0);
    rd(3'd1, v); chk("R2 source final", v, {4'd0, es});
    rd(3'd2, v); chk("R2 destination final", v, {4'd0, ed});
  endtask

  initial begin
    #750000;
    n_chk++; n_bad++;
    $display("FAIL watchdog expired");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    logic [31:0] v;
    int base;
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    // R13 reset state
    chk("R13 req low", {31'd0, req}, 32'd0);
    chk("R13 done low", {31'd0, done}, 32'd0);
    for (int a = 0; a < 8; a++) begin
      rd(3'(a), v); chk("R13 register reset", v, 32'd0);
    end
    // R1 reserved bits
    wr(3'd0, 32'hFFFF_FF00); rd(3'd0, v); chk("R1 ctrl reserved", v, 32'd0);
    wr(3'd0, 32'hFFFF_FFA6); rd(3'd0, v); chk("R1 ctrl fields", v, 32'h0000_00A6);
    wr(3'd1, 32'hFFFF_FFFF); rd(3'd1, v); chk("R1 source width", v, 32'h0FFF_FFFF);
    wr(3'd3, 32'hFFFF_FFFF); rd(3'd3, v); chk("R1 count width", v, 32'h00FF_FFFF);
    wr(3'd4, 32'hFFFF_FFFE); rd(3'd4, v); chk("R1 enable width", v, 32'd0);
    rd(3'd6, v); chk("R1 index 6", v, 32'd0);
    rd(3'd7, v); chk("R1 index 7", v, 32'd0);

    // main sweep
    for (int m = 0; m < 3; m++)
      for (int sc = 0; sc < 4; sc++)
        for (int dc = 0; dc < 4; dc++)
          for (int du = 0; du < 2; du++)
            run_case(m, sc, dc, du, 28'h000_0001, 28'hFFF_FFFE,
                     (m == 0) ? 24'd2 : (m == 1) ? 24'd3 : 24'h000203);

    // R5 block length 0 means 256
    run_case(2, 3, 0, 0, 28'h000_0100, 28'h0, 24'h000100);
    // R5 reload across blocks in dual mode
    run_case(2, 2, 2, 1, 28'h123_4560, 28'h0AB_CDE0, 24'h000304);

    // R7 zero count
    wr(3'd0, 32'h0); wr(3'd3, 32'd0); wr(3'd4, 32'd1);
    base = done_cnt;
    pulse_trig();
    no_req("R7 zero count", 4);
    chk("R7 zero count done", 32'(done_cnt - base), 32'd1);
    rd(3'd4, v); chk("R7 zero count enable cleared", v, 32'd0);

    // R8 disabled channel
    wr(3'd0, 32'h01); wr(3'd3, 32'd4);
    pulse_trig();
    no_req("R8 disabled", 4);
    rd(3'd5, v); chk("R8 flag stays clear", v, 32'd0);
    rd(3'd3, v); chk("R8 count unchanged", v, 32'd4);

    // R10 invalid mode
    wr(3'd0, 32'h03); wr(3'd3, 32'd7); wr(3'd1, 32'h55); wr(3'd4, 32'd1);
    pulse_trig();
    no_req("R10 invalid", 5);
    rd(3'd5, v); chk("R10 flag not set", v, 32'd0);
    rd(3'd3, v); chk("R10 count unchanged", v, 32'd7);
    rd(3'd1, v); chk("R10 source unchanged", v, 32'h55);
    rd(3'd4, v); chk("R10 enable unchanged", v, 32'd1);
    wr(3'd4, 32'd0);

    // R11 stall, R9 flag, R12 write lock
    wr(3'd0, 32'h7D); wr(3'd1, 32'h100); wr(3'd2, 32'h200); wr(3'd3, 32'd2); wr(3'd4, 32'd1);
    gnt = 1'b0;
    base = done_cnt;
    pulse_trig();
    wait_req("R11");
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      chk("R11 req held", {31'd0, req}, 32'd1);
      chk("R11 addr held", {4'd0, req_addr}, 32'h100);
      chk("R11 we held", {31'd0, req_we}, 32'd0);
    end
    pulse_trig();
    rd(3'd5, v); chk("R9 flag set by trigger", v, 32'd1);
    wr(3'd5, 32'd0); rd(3'd5, v); chk("R9 write 0 no effect", v, 32'd1);
    wr(3'd5, 32'd1); rd(3'd5, v); chk("R9 write 1 clears", v, 32'd0);
    wr(3'd3, 32'd5); rd(3'd3, v); chk("R12 count write ignored", v, 32'd2);
    wr(3'd4, 32'd0); rd(3'd4, v); chk("R12 enable write ignored", v, 32'd1);
    wr(3'd0, 32'h00); rd(3'd0, v); chk("R12 ctrl write ignored", v, 32'h7D);
    wr(3'd1, 32'h999); rd(3'd1, v); chk("R12 source write ignored", v, 32'h100);
    gnt = 1'b1;
    for (int t = 0; t < 100 && req; t++) @(negedge clk);
    repeat (2) @(negedge clk);
    chk("R7 stalled run done", 32'(done_cnt - base), 32'd1);
    rd(3'd1, v); chk("R2 stalled run source", v, 32'h102);
    rd(3'd2, v); chk("R2 stalled run destination", v, 32'h202);
    rd(3'd5, v); chk("R9 flag consumed", v, 32'd0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule